// File: doc/BRIEF.md
# Manual RAM entry and display

A small memory exerciser for on-chip storage. A 32-word by 4-bit synchronous RAM comes up holding a few known values, so a board can show that it works before any write. One push button steps a 5-bit address forward. A second push button stores the value set on four switches at that address. The word at the current address is read all the time and decoded onto one seven-segment digit.

Both buttons are active low. Each one passes through a two-flip-flop synchroniser and a falling-edge detector, so one press gives exactly one single-cycle action, however long the button is held. Reset sends the address back to zero and leaves the memory contents alone.

Top module: `nibble_ram_panel`

## Requirements
- R1: The memory holds 32 words of 4 bits, selected by the 5-bit `addr` output. A write changes only the word at the current address.
- R2: Without any write, words 0, 1, 2 and 3 hold 2, 4, 6 and 8. All other words start at 0.
- R3: Write data is `sw`, with `sw[0]` as the least significant bit and `sw[3]` as the most significant bit.
- R4: A write press stores `sw` at `addr`. The display shows the stored value from the cycle after the write edge on.
- R5: An increment press adds one to `addr`. The address wraps from 31 to 0.
- R6: A button acts once per falling edge. If the button input falls just before clock edge k, the action takes effect at edge k+2. Holding the button low gives no further action.
- R7: While `rst_n` is low, `addr` is 0. Reset does not change the memory contents.
- R8: `seg_n` is active low with bit 0 = segment a through bit 6 = segment g. Values 0 to 9 show as decimal digits. Values 10 to 15 show as A, b, C, d, E and F. The active-high patterns, as hex numbers, are 3F 06 5B 4F 66 6D 7D 07 7F 6F 77 7C 39 5E 79 71.
- R9: If both buttons act on the same cycle, the write goes to the old address and the address then increments.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sw | input | 4 | Write data switches |
| btn_wr_n | input | 1 | Write push button, active low |
| btn_inc_n | input | 1 | Address increment push button, active low |
| seg_n | output | 7 | Segment lines a to g, active low |
| addr | output | 5 | Current address |

## Verification
On every cycle the assertions check four things:
- the address steps by exactly one after an increment pulse and holds at other times;
- each detected press lasts a single cycle;
- a write puts the switch value on the read port on the following cycle;
- a combined press does both actions.

The preloaded values, the wrap at 31, the two-edge synchroniser delay, the retention of memory across reset and the full segment table can only be shown by the bench scenarios. Those scenarios compare the outputs with a model of the memory and address.

// File: rtl/nibble_ram_panel.sv
`timescale 1ns/1ps
module nibble_ram_panel #(
  parameter int AW = 5,
  parameter int DW = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] sw,
  input  logic          btn_wr_n,
  input  logic          btn_inc_n,
  output logic [6:0]    seg_n,
  output logic [AW-1:0] addr
);
  localparam int DEPTH = 1 << AW;

  logic [2:0]    wr_sh, inc_sh;
  logic          wr_p, inc_p;
  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] rd_q;
  logic [6:0]    seg_on;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      wr_sh  <= '1;
      inc_sh <= '1;
    end else begin
      wr_sh  <= {wr_sh[1:0], btn_wr_n};
      inc_sh <= {inc_sh[1:0], btn_inc_n};
    end

  assign wr_p  = wr_sh[2] & ~wr_sh[1];
  assign inc_p = inc_sh[2] & ~inc_sh[1];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     addr <= '0;
    else if (inc_p) addr <= addr + 1'b1;

  initial
    for (int i = 0; i < DEPTH; i++)
      mem[i] = (i < 4) ? DW'(2 * (i + 1)) : '0;

  always_ff @(posedge clk) begin
    if (wr_p) mem[addr] <= sw;
    rd_q <= wr_p ? sw : mem[addr];
  end

  always_comb
    case (rd_q[3:0])
      4'h0: seg_on = 7'h3F;
      4'h1: seg_on = 7'h06;
      4'h2: seg_on = 7'h5B;
      4'h3: seg_on = 7'h4F;
      4'h4: seg_on = 7'h66;
      4'h5: seg_on = 7'h6D;
      4'h6: seg_on = 7'h7D;
      4'h7: seg_on = 7'h07;
      4'h8: seg_on = 7'h7F;
      4'h9: seg_on = 7'h6F;
      4'hA: seg_on = 7'h77;
      4'hB: seg_on = 7'h7C;
      4'hC: seg_on = 7'h39;
      4'hD: seg_on = 7'h5E;
      4'hE: seg_on = 7'h79;
      default: seg_on = 7'h71;
    endcase

  assign seg_n = ~seg_on;
endmodule

// File: rtl/nibble_ram_panel_chk.sv
`timescale 1ns/1ps
module nibble_ram_panel_chk #(
  parameter int AW = 5,
  parameter int DW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic [DW-1:0] sw,
  input logic [AW-1:0] addr,
  input logic          wr_p,
  input logic          inc_p,
  input logic [DW-1:0] rd_q
);
  a_r5_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
    inc_p |=> addr == $past(addr) + 1'b1);

  a_r5_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !inc_p |=> $stable(addr));

  a_r6_inc_single: assert property (@(posedge clk) disable iff (!rst_n)
    inc_p |=> !inc_p);

  a_r6_wr_single: assert property (@(posedge clk) disable iff (!rst_n)
    wr_p |=> !wr_p);

  a_r4_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    wr_p |=> rd_q == $past(sw));

  a_r9_both_actions: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_p && inc_p) |=> (rd_q == $past(sw)) && (addr == $past(addr) + 1'b1));
endmodule

bind nibble_ram_panel nibble_ram_panel_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .sw(sw), .addr(addr),
  .wr_p(wr_p), .inc_p(inc_p), .rd_q(rd_q)
);

// File: tb/nibble_ram_panel_bench.sv
`timescale 1ns/1ps
module nibble_ram_panel_bench;
  logic       clk = 0;
  logic       rst_n = 0;
  logic [3:0] sw = 0;
  logic       btn_wr_n = 1, btn_inc_n = 1;
  logic [6:0] seg_n;
  logic [4:0] addr;

  int errors = 0, checks = 0;
  logic [3:0] mem_m [32];
  logic [4:0] addr_m;

  always #4 clk = ~clk;

  nibble_ram_panel u_nibble_ram_panel (
    .clk(clk), .rst_n(rst_n), .sw(sw), .btn_wr_n(btn_wr_n),
    .btn_inc_n(btn_inc_n), .seg_n(seg_n), .addr(addr)
  );

  function automatic logic [6:0] exp_seg(input logic [3:0] v);
    logic [6:0] on;
    case (v)
      0: on = 7'h3F;  1: on = 7'h06;  2: on = 7'h5B;  3: on = 7'h4F;
      4: on = 7'h66;  5: on = 7'h6D;  6: on = 7'h7D;  7: on = 7'h07;
      8: on = 7'h7F;  9: on = 7'h6F; 10: on = 7'h77; 11: on = 7'h7C;
      12: on = 7'h39; 13: on = 7'h5E; 14: on = 7'h79; default: on = 7'h71;
    endcase
    return ~on;
  endfunction

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic chk_out(input string tag);
    chk(addr == addr_m, tag, addr, addr_m);
    chk(seg_n == exp_seg(mem_m[addr_m]), tag, seg_n, exp_seg(mem_m[addr_m]));
  endtask

  task automatic press(input bit do_wr, input bit do_inc, input logic [3:0] v);
    sw = v;
    if (do_wr)  btn_wr_n = 0;
    if (do_inc) btn_inc_n = 0;
    tick(4);
    btn_wr_n = 1;
    btn_inc_n = 1;
    tick(4);
    if (do_wr)  mem_m[addr_m] = v;
    if (do_inc) addr_m = addr_m + 1'b1;
  endtask

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_0042);
    for (int i = 0; i < 32; i++) mem_m[i] = (i < 4) ? 4'(2 * (i + 1)) : 4'd0;
    addr_m = 0;
    tick(3);
    chk(addr == 0, "R7 addr in reset", addr, 0);
    rst_n = 1;
    tick(2);
    chk_out("R2 word0 after reset");

    for (int i = 1; i < 4; i++) begin
      press(0, 1, 4'hF);
      chk_out("R2 preload / R5 step");
    end

    begin
      logic [4:0] a0;
      a0 = addr;
      btn_inc_n = 0;
      tick(1);
      chk(addr == a0, "R6 no action edge k", addr, a0);
      tick(1);
      chk(addr == a0, "R6 no action edge k+1", addr, a0);
      tick(1);
      chk(addr == a0 + 5'd1, "R6 action at edge k+2", addr, a0 + 5'd1);
      tick(10);
      chk(addr == a0 + 5'd1, "R6 held button one action", addr, a0 + 5'd1);
      btn_inc_n = 1;
      tick(4);
      addr_m = addr_m + 1'b1;
    end

    press(1, 0, 4'b0001);
    chk_out("R3 sw0 is lsb");
    press(1, 0, 4'b1000);
    chk_out("R3 sw3 is msb");

    for (int v = 0; v < 16; v++) begin
      press(1, 0, 4'(v));
      chk_out("R8 segment table / R4 write");
    end

    while (addr_m != 5'd31) press(0, 1, 4'h0);
    chk_out("R5 reach 31");
    press(0, 1, 4'h0);
    chk_out("R5 wrap to 0");

    press(1, 1, 4'hC);
    chk_out("R9 both increments");
    chk(mem_m[0] == 4'hC, "R9 model", mem_m[0], 4'hC);
    press(0, 0, 4'h0);
    for (int i = 0; i < 31; i++) press(0, 1, 4'h3);
    chk_out("R9 write went to old address");

    for (int n = 0; n < 200; n++) begin
      int op;
      op = $urandom_range(0, 3);
      press(op[0], op[1], 4'($urandom_range(0, 15)));
      chk_out("R1 random ops");
    end

    rst_n = 0;
    tick(2);
    chk(addr == 0, "R7 reset addr zero", addr, 0);
    rst_n = 1;
    addr_m = 0;
    for (int i = 0; i < 32; i++) begin
      tick(2);
      chk_out("R7 memory kept over reset / R1");
      press(0, 1, 4'h0);
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule